// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a link to a 16-bit sampling converter that has a serial output port. It generates a data clock that runs without pause and drives the converter's chip-select and convert-start lines. On request it starts a conversion and checks that the converter answers by pulling BUSY low. It then waits for the framing SYNC pulse that the converter sends back. After SYNC it shifts in the previous conversion's 16-bit result, MSB first, while the new conversion is still running.

Framing comes only from SYNC, never from a chip-select edge. This is needed because chip-select cannot stay low when the clock never stops. All converter inputs are sampled in the system-clock cycle that follows a falling data-clock edge. The data clock is the system clock divided by `DIV`, and `DIV` is at least 4. The converter changes its outputs on rising edges, so each sample is taken half a data-clock period after the value changed. If SYNC does not arrive within a bounded number of cycles, the block flags a framing error. If BUSY never drops, it flags a start error. In both cases it returns to idle with the bus released.

Top module: `adc_serial_reader`

## Requirements
- R1: `dclk_o` toggles continuously from reset in every state, with a period of `DIV` system cycles: high for `DIV/2` cycles, then low for `DIV/2` cycles (default `DIV`=4 gives the pattern 1,1,0,0).
- R2: While `rst_ni` is low and just after it is released, `cs_no`=1, `conv_no`=1, `word_o`=0, `word_valid_o`=0, `frame_err_o`=0 and `start_err_o`=0.
- R3: A `start_i` pulse in idle makes `cs_no` and `conv_no` go low together just after a falling `dclk_o` edge. `conv_no` stays low across exactly one rising edge (pulse #0) and goes high again on the next falling edge. `conv_no` is never low while `cs_no` is high.
- R4: `busy_i` is sampled at the falling edge where `conv_no` is released. If it is still high, `start_err_o` pulses for one cycle, `cs_no` goes high, no word is produced, and `word_o` keeps its value.
- R5: From pulse #1 on, `sync_i` is sampled on each falling edge. The first falling edge that sees `sync_i`=1 locks the framing. The next 16 falling edges capture `data_i`, MSB first. Bits after the 16th are not captured.
- R6: If no SYNC has been seen after `SYNC_LIMIT`+1 system cycles in the wait state, `frame_err_o` pulses for one cycle, `cs_no` goes high and `word_o` is unchanged. With the defaults this is reached on falling edge #3: SYNC on edge #1, #2 or #3 is accepted, and SYNC on edge #4 or later is not.
- R7: After the 16th bit, `word_o` takes the captured word, `word_valid_o` is 1 for exactly one cycle, and `cs_no` goes high in that same cycle. `word_o` then holds its value until the next word completes.
- R8: A `start_i` pulse while a transaction is running is ignored. It causes no second transaction and no second `word_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion-plus-readout |
| busy_i | input | 1 | Converter BUSY, low while converting |
| sync_i | input | 1 | Converter framing pulse |
| data_i | input | 1 | Converter serial data |
| dclk_o | output | 1 | Free-running data clock |
| cs_no | output | 1 | Chip-select, active low |
| conv_no | output | 1 | Convert-start, low starts a conversion |
| word_o | output | W | Last captured result |
| word_valid_o | output | 1 | One-cycle strobe when word_o updates |
| frame_err_o | output | 1 | One-cycle strobe, SYNC timeout |
| start_err_o | output | 1 | One-cycle strobe, BUSY did not fall |

## Verification
The hardest case to reach from the ports is a SYNC pulse that lands on the boundary of the timeout window. SYNC on falling edge #3 must still frame the word, and SYNC one edge later must give a framing error. The bench's converter model counts data-clock rising edges from the start strobe. It can delay both its SYNC pulse and its data by a chosen number of clock pulses, so both sides of the boundary are driven with a known word. The model also drives ones after the 16th bit, so a controller that over-captures corrupts an all-zero word.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    RD_IDLE,
    RD_ARM,
    RD_SYNC,
    RD_DATA
  } rd_state_e;
endpackage

// File: rtl/adc_dclk_gen.sv
module adc_dclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic dclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (cnt_q == CW'(DIV - 1)) cnt_nxt = '0;
    else                       cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(DIV - 1);
      dclk_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      dclk_o <= (cnt_nxt < CW'(HALF));
      rise_o <= (cnt_nxt == '0);
      fall_o <= (cnt_nxt == CW'(HALF));
    end
  end
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
  import adc_rd_pkg::*;
#(
  parameter int W          = 16,
  parameter int SYNC_LIMIT = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fall_i,
  input  logic busy_i,
  input  logic sync_i,
  output logic cs_no,
  output logic conv_no,
  output logic shift_o,
  output logic load_o,
  output logic frame_err_o,
  output logic start_err_o
);
  localparam int BW = $clog2(W);
  localparam int TW = $clog2(SYNC_LIMIT + 1);

  rd_state_e     state_q;
  logic          pend_q;
  logic [BW-1:0] bit_q;
  logic [TW-1:0] tmr_q;

  assign shift_o = (state_q == RD_DATA) && fall_i;
  assign load_o  = shift_o && (bit_q == BW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RD_IDLE;
      pend_q      <= 1'b0;
      bit_q       <= '0;
      tmr_q       <= '0;
      cs_no       <= 1'b1;
      conv_no     <= 1'b1;
      frame_err_o <= 1'b0;
      start_err_o <= 1'b0;
    end else begin
      frame_err_o <= 1'b0;
      start_err_o <= 1'b0;
      unique case (state_q)
        RD_IDLE: begin
          if (start_i) pend_q <= 1'b1;
          if (fall_i && (pend_q || start_i)) begin
            pend_q  <= 1'b0;
            cs_no   <= 1'b0;
            conv_no <= 1'b0;
            state_q <= RD_ARM;
          end
        end
        RD_ARM: begin
          // pulse #0 has risen; release convert-start on its falling edge
          if (fall_i) begin
            conv_no <= 1'b1;
            tmr_q   <= '0;
            if (busy_i) begin
              start_err_o <= 1'b1;
              cs_no       <= 1'b1;
              state_q     <= RD_IDLE;
            end else begin
              state_q <= RD_SYNC;
            end
          end
        end
        RD_SYNC: begin
          if (fall_i && sync_i) begin
            bit_q   <= '0;
            state_q <= RD_DATA;
          end else if (tmr_q == TW'(SYNC_LIMIT)) begin
            frame_err_o <= 1'b1;
            cs_no       <= 1'b1;
            state_q     <= RD_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        RD_DATA: begin
          if (fall_i) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == BW'(W - 1)) begin
              cs_no   <= 1'b1;
              state_q <= RD_IDLE;
            end
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_shift_capture.sv
module adc_shift_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         load_i,
  input  logic         data_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  logic [W-1:0] sr_q, sr_nxt;

  assign sr_nxt = {sr_q[W-2:0], data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (shift_i) sr_q <= sr_nxt;
      if (load_i)  word_o <= sr_nxt;
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int W          = 16,
  parameter int DIV        = 4,
  parameter int SYNC_LIMIT = 3 * DIV - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         busy_i,
  input  logic         sync_i,
  input  logic         data_i,
  output logic         dclk_o,
  output logic         cs_no,
  output logic         conv_no,
  output logic [W-1:0] word_o,
  output logic         word_valid_o,
  output logic         frame_err_o,
  output logic         start_err_o
);
  logic rise, fall, shift, load;

  adc_dclk_gen #(.DIV(DIV)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dclk_o(dclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  adc_frame_fsm #(.W(W), .SYNC_LIMIT(SYNC_LIMIT)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .fall_i     (fall),
    .busy_i     (busy_i),
    .sync_i     (sync_i),
    .cs_no      (cs_no),
    .conv_no    (conv_no),
    .shift_o    (shift),
    .load_o     (load),
    .frame_err_o(frame_err_o),
    .start_err_o(start_err_o)
  );

  adc_shift_capture #(.W(W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .load_i (load),
    .data_i (data_i),
    .word_o (word_o),
    .valid_o(word_valid_o)
  );

  logic unused_rise;
  assign unused_rise = rise;
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         dclk_o,
  input logic         cs_no,
  input logic         conv_no,
  input logic [W-1:0] word_o,
  input logic         word_valid_o,
  input logic         frame_err_o,
  input logic         start_err_o
);
  a_r1_dclk_high_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |=> dclk_o);

  a_r3_conv_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_no |-> !cs_no);

  a_r4_start_err_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_err_o |-> (cs_no && conv_no && !word_valid_o));

  a_r6_frame_err_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (cs_no && conv_no && !word_valid_o && $stable(word_o)));

  a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  a_r7_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));

  a_r7_cs_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> cs_no);
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dclk_o      (dclk_o),
  .cs_no       (cs_no),
  .conv_no     (conv_no),
  .word_o      (word_o),
  .word_valid_o(word_valid_o),
  .frame_err_o (frame_err_o),
  .start_err_o (start_err_o)
);

// File: tb/adc_serial_reader_bench.sv
`timescale 1ns/1ps
module adc_serial_reader_bench;
  localparam int W = 16;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy = 1'b1, sync = 1'b0, data = 1'b0;
  logic dclk, cs_n, conv_n, vld, ferr, serr;
  logic [W-1:0] word;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // converter model settings
  logic [W-1:0] m_word = '0;
  int  m_dly = 0;
  bit  m_sync_en = 1, m_busy_stuck = 0, m_active = 0;
  int  m_p = -1, m_conv_rises = 0;

  always #4 clk = ~clk;

  adc_serial_reader #(.W(W), .DIV(DIV)) u_adc_serial_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_i(busy),
    .sync_i(sync), .data_i(data), .dclk_o(dclk), .cs_no(cs_n),
    .conv_no(conv_n), .word_o(word), .word_valid_o(vld),
    .frame_err_o(ferr), .start_err_o(serr));

  always @(negedge conv_n) if (!cs_n) begin
    m_active = 1; m_p = -1; m_conv_rises = 0;
    #2 if (!m_busy_stuck) busy = 1'b0;
  end

  always @(posedge cs_n) begin
    m_active = 0; busy = 1'b1; sync = 1'b0; data = 1'b0;
  end

  always @(posedge dclk) if (m_active) begin
    int idx;
    m_p++;
    if (!conv_n) m_conv_rises++;
    #1;
    sync = m_sync_en && (m_p == 1 + m_dly);
    idx = m_p - (2 + m_dly);
    data = (idx >= 0 && idx < W) ? m_word[W-1-idx] : 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      finish_run();
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // returns 0 none, 1 valid, 2 frame err, 3 start err
  task automatic wait_end(output int kind);
    kind = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (vld) begin kind = 1; break; end
      if (ferr) begin kind = 2; break; end
      if (serr) begin kind = 3; break; end
    end
  endtask

  task automatic t_reset();
    check("R2 cs_no", cs_n, 1); check("R2 conv_no", conv_n, 1);
    check("R2 word", word, 0);  check("R2 valid", vld, 0);
    check("R2 errs", {ferr, serr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 cs_no after", cs_n, 1);
  endtask

  task automatic t_dclk();
    logic [7:0] pat;
    @(posedge dclk);
    for (int i = 0; i < 8; i++) begin @(negedge clk); pat[7-i] = dclk; end
    check("R1 dclk pattern", pat, 8'b1100_1100);
  endtask

  task automatic t_read(logic [W-1:0] w, int dly, string tag);
    int kind;
    logic [W-1:0] prev;
    prev = word;
    m_word = w; m_dly = dly; m_sync_en = 1; m_busy_stuck = 0;
    pulse_start();
    wait_end(kind);
    check({"R5 word done ", tag}, kind, 1);
    check({"R5 word value ", tag}, word, w);
    check({"R3 one rise with conv low ", tag}, m_conv_rises, 1);
    check({"R7 cs released ", tag}, cs_n, 1);
    @(negedge clk);
    check({"R7 valid one cycle ", tag}, vld, 0);
    repeat (8) @(negedge clk);
    check({"R7 word held ", tag}, word, w);
    if (prev == w) check("R7 repeat word", word, prev);
  endtask

  task automatic t_frame_err(int dly, bit en);
    int kind;
    logic [W-1:0] prev;
    prev = word;
    m_word = 16'h1234; m_dly = dly; m_sync_en = en; m_busy_stuck = 0;
    pulse_start();
    wait_end(kind);
    check("R6 frame error", kind, 2);
    check("R6 cs released", cs_n, 1);
    check("R6 word unchanged", word, prev);
    repeat (40) @(negedge clk);
    check("R6 no late word", vld, 0);
  endtask

  task automatic t_busy_stuck();
    int kind;
    logic [W-1:0] prev;
    prev = word;
    m_word = 16'h0F0F; m_dly = 0; m_sync_en = 1; m_busy_stuck = 1;
    pulse_start();
    wait_end(kind);
    check("R4 start error", kind, 3);
    check("R4 cs released", {cs_n, conv_n}, 2'b11);
    check("R4 word unchanged", word, prev);
    m_busy_stuck = 0;
  endtask

  task automatic t_start_ignored();
    int kind, extra;
    m_word = 16'h5A5A; m_dly = 0; m_sync_en = 1;
    pulse_start();
    repeat (30) @(negedge clk);
    check("R8 busy reading", cs_n, 0);
    pulse_start();
    wait_end(kind);
    check("R8 first word", kind, 1);
    check("R8 word value", word, 16'h5A5A);
    extra = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (vld || ferr || serr || !cs_n) extra++;
    end
    check("R8 no second transaction", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_dclk();
    t_read(16'hA5C3, 0, "a5c3");
    t_read(16'h8001, 0, "8001");
    t_read(16'h0000, 0, "zero tag ones");
    t_read(16'hFFFF, 0, "ffff");
    t_read(16'h3C96, 1, "sync edge2");
    t_read(16'hC35A, 2, "sync edge3");
    t_frame_err(3, 1);
    t_frame_err(0, 0);
    t_busy_stuck();
    t_read(16'h7E81, 0, "after errors");
    t_start_ignored();
    finish_run();
  end
endmodule